// File: doc/BRIEF.md
# Sticky Multi-Lane Exception Flag Register

This block gathers exception indications from two groups of compute lanes and keeps them as sticky bits in one 7-bit status word. The matrix group reports exponent underflow, infinity or overflow, and integer accumulation saturation. The vector group reports NaN, infinity, denormal, and integer addition overflow. Each group has `LANES` lanes. Each lane has its own valid bit and one bit per exception kind. All of these are taken from the results that the lanes produce. Operand values are never examined.

An indication counts only when the valid bit of its lane is high. Each exception kind is OR-reduced across all lanes of its group, so the status word does not record which lane raised it. A bit that has been set stays set until software pulses the clear strobe. If a new event arrives in the same cycle as the clear, the event wins and its bit is set after that cycle.

Software reads the word through a single-register read port. One cycle after `rd_en` is high, `rd_data` shows the status as it was at that edge, with the unused upper bits at zero. Between reads, `rd_data` holds its last value. Two helper outputs present the matrix-group bits and the vector-group bits on their own.

The block has no state machine. Each flag is an independent set/clear register with two conditions:
- Set: a valid lane reports the event.
- Clear: the clear strobe is high and no valid lane reports the event in that cycle.

Top module: `lane_exc_status`

## Requirements
- R1: After reset, `status`, `mx_flags`, `vx_flags` and `rd_data` are all zero.
- R2: If any matrix lane has valid and underflow high in a cycle, `status[6]` is 1 from the next cycle on.
- R3: If any matrix lane has valid and infinity/overflow high in a cycle, `status[5]` is 1 from the next cycle on.
- R4: If any matrix lane has valid and integer saturation high in a cycle, `status[4]` is 1 from the next cycle on.
- R5: If any vector lane has valid and NaN, infinity or denormal high in a cycle, `status[3]`, `status[2]` or `status[1]` respectively is 1 from the next cycle on.
- R6: If any vector lane has valid and integer addition overflow high in a cycle, `status[0]` is 1 from the next cycle on.
- R7: A set bit stays 1 in every later cycle until `clr` is high.
- R8: `clr` high in a cycle with no valid event makes `status` zero in the next cycle.
- R9: When `clr` and a valid event for bit k occur in the same cycle, bit k is 1 in the next cycle and the other bits are 0.
- R10: An exception bit on a lane whose valid bit is low has no effect on `status`.
- R11: An event on any lane index, including lane 0 and lane `LANES-1`, sets the flag. Events on several lanes at once set the same single bit.
- R12: With `rd_en` high at an edge, `rd_data` holds `{25'b0, status}` as sampled at that edge, and keeps that value while `rd_en` is low.
- R13: `mx_flags` always equals `status[6:4]` and `vx_flags` always equals `status[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mx_valid | input | LANES | Matrix lane result valid |
| mx_undf | input | LANES | Matrix lane exponent underflow |
| mx_ovf | input | LANES | Matrix lane infinity/overflow |
| mx_sat | input | LANES | Matrix lane integer accumulation saturation |
| vx_valid | input | LANES | Vector lane result valid |
| vx_nan | input | LANES | Vector lane NaN result |
| vx_inf | input | LANES | Vector lane infinity result |
| vx_den | input | LANES | Vector lane denormal result |
| vx_iovf | input | LANES | Vector lane integer addition overflow |
| clr | input | 1 | Software clear strobe |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Read data, status zero-extended |
| status | output | 7 | Sticky status word |
| mx_flags | output | 3 | Matrix-group flags (status[6:4]) |
| vx_flags | output | 4 | Vector-group flags (status[3:0]) |

## Verification
The bench first drives one exception at a time, each on a different lane, to confirm that every kind lands on its own bit position. A swapped field would show up as the wrong bit being set. It then pulses exceptions with valid low; a design that ignores valid would raise flags on idle lanes. Clear is tested in the same cycle as a new event, where a clear-priority design would drop the event. Stickiness is tested over several idle cycles, where a design that decays or re-samples the flags would lose them. Reads are tested before and after a later update, where an unregistered or non-holding read port would show the wrong word.

// File: rtl/exc_flag_pkg.sv
package exc_flag_pkg;
    localparam int MX_FLAGS = 3;
    localparam int VX_FLAGS = 4;
    localparam int STATUS_W = MX_FLAGS + VX_FLAGS;
    localparam int RD_W     = 32;
endpackage

// File: rtl/lane_or_reduce.sv
module lane_or_reduce #(
    parameter int LANES = 4,
    parameter int FLAGS = 3
) (
    input  logic [LANES-1:0]            valid,
    input  logic [FLAGS-1:0][LANES-1:0] ev,
    output logic [FLAGS-1:0]            hit
);
    for (genvar f = 0; f < FLAGS; f++) begin : g_flag
        assign hit[f] = |(valid & ev[f]);
    end
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= set;
        else          q <= q | set;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (($past(q) & ~q) == '0));                        // R7
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set == '0) |=> (q == '0));                        // R8
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((q & $past(set)) == $past(set)));        // R9
endmodule

// File: rtl/status_read_port.sv
module status_read_port #(
    parameter int SW = 7,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [SW-1:0] stat,
    output logic [DW-1:0] rd_data
);
    localparam int PAD = DW - SW;

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= {{PAD{1'b0}}, stat};
    end

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));                             // R12
endmodule

// File: rtl/lane_exc_status.sv
module lane_exc_status
    import exc_flag_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES-1:0]    mx_valid,
    input  logic [LANES-1:0]    mx_undf,
    input  logic [LANES-1:0]    mx_ovf,
    input  logic [LANES-1:0]    mx_sat,
    input  logic [LANES-1:0]    vx_valid,
    input  logic [LANES-1:0]    vx_nan,
    input  logic [LANES-1:0]    vx_inf,
    input  logic [LANES-1:0]    vx_den,
    input  logic [LANES-1:0]    vx_iovf,
    input  logic                clr,
    input  logic                rd_en,
    output logic [RD_W-1:0]     rd_data,
    output logic [STATUS_W-1:0] status,
    output logic [MX_FLAGS-1:0] mx_flags,
    output logic [VX_FLAGS-1:0] vx_flags
);
    logic [MX_FLAGS-1:0] mx_hit;
    logic [VX_FLAGS-1:0] vx_hit;

    // index order gives bit order inside each group: undf->6, ovf->5, sat->4
    lane_or_reduce #(.LANES(LANES), .FLAGS(MX_FLAGS)) u_mx_red (
        .valid (mx_valid),
        .ev    ({mx_undf, mx_ovf, mx_sat}),
        .hit   (mx_hit)
    );

    // nan->3, inf->2, den->1, iovf->0
    lane_or_reduce #(.LANES(LANES), .FLAGS(VX_FLAGS)) u_vx_red (
        .valid (vx_valid),
        .ev    ({vx_nan, vx_inf, vx_den, vx_iovf}),
        .hit   (vx_hit)
    );

    sticky_bank #(.W(STATUS_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set   ({mx_hit, vx_hit}),
        .clr   (clr),
        .q     (status)
    );

    status_read_port #(.SW(STATUS_W), .DW(RD_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .stat    (status),
        .rd_data (rd_data)
    );

    assign mx_flags = status[STATUS_W-1:VX_FLAGS];
    assign vx_flags = status[VX_FLAGS-1:0];

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && mx_valid == '0 && vx_valid == '0) |=> (status == '0));  // R10
endmodule

// File: tb/lane_exc_status_tb.sv
module lane_exc_status_tb;
    localparam int L = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [L-1:0] mx_valid = '0, mx_undf = '0, mx_ovf = '0, mx_sat = '0;
    logic [L-1:0] vx_valid = '0, vx_nan = '0, vx_inf = '0, vx_den = '0, vx_iovf = '0;
    logic clr = 1'b0, rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [6:0]  status;
    logic [2:0]  mx_flags;
    logic [3:0]  vx_flags;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    lane_exc_status #(.LANES(L)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .mx_valid(mx_valid), .mx_undf(mx_undf), .mx_ovf(mx_ovf), .mx_sat(mx_sat),
        .vx_valid(vx_valid), .vx_nan(vx_nan), .vx_inf(vx_inf), .vx_den(vx_den),
        .vx_iovf(vx_iovf), .clr(clr), .rd_en(rd_en),
        .rd_data(rd_data), .status(status), .mx_flags(mx_flags), .vx_flags(vx_flags)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        mx_valid = '0; mx_undf = '0; mx_ovf = '0; mx_sat = '0;
        vx_valid = '0; vx_nan = '0; vx_inf = '0; vx_den = '0; vx_iovf = '0;
        clr = 1'b0; rd_en = 1'b0;
    endtask

    // inputs set at a negedge are taken at the next posedge; status checked one negedge later
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        step();
    endtask

    task automatic t_reset();
        chk("R1 status", {25'b0, status}, 32'h0);
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 helpers", {25'b0, mx_flags, vx_flags}, 32'h0);
    endtask

    task automatic t_single_bits();
        @(negedge clk); mx_valid = 4'b0001; mx_undf = 4'b0001; step();
        chk("R2 underflow->bit6", {25'b0, status}, 32'h40);
        do_clear();
        @(negedge clk); mx_valid = 4'b1000; mx_ovf = 4'b1000; step();
        chk("R3 overflow->bit5 R11 top lane", {25'b0, status}, 32'h20);
        do_clear();
        @(negedge clk); mx_valid = 4'b0100; mx_sat = 4'b0100; step();
        chk("R4 saturation->bit4", {25'b0, status}, 32'h10);
        do_clear();
        @(negedge clk); vx_valid = 4'b0010; vx_nan = 4'b0010; step();
        chk("R5 nan->bit3", {25'b0, status}, 32'h08);
        do_clear();
        @(negedge clk); vx_valid = 4'b1000; vx_inf = 4'b1000; step();
        chk("R5 inf->bit2", {25'b0, status}, 32'h04);
        do_clear();
        @(negedge clk); vx_valid = 4'b0001; vx_den = 4'b0001; step();
        chk("R5 den->bit1", {25'b0, status}, 32'h02);
        do_clear();
        @(negedge clk); vx_valid = 4'b0100; vx_iovf = 4'b0100; step();
        chk("R6 iovf->bit0", {25'b0, status}, 32'h01);
        do_clear();
        chk("R8 clear empties", {25'b0, status}, 32'h0);
    endtask

    task automatic t_valid_mask();
        @(negedge clk);
        mx_valid = 4'b1010; mx_undf = 4'b0101; mx_ovf = 4'b0101; mx_sat = 4'b0101;
        vx_valid = 4'b0000; vx_nan = '1; vx_inf = '1; vx_den = '1; vx_iovf = '1;
        step();
        chk("R10 invalid lanes ignored", {25'b0, status}, 32'h0);
    endtask

    task automatic t_multi_lane();
        @(negedge clk); vx_valid = '1; vx_inf = '1; mx_valid = 4'b1001; mx_sat = 4'b1001; step();
        chk("R11 multi lanes one bit", {25'b0, status}, 32'h14);
        chk("R13 mx_flags", {29'b0, mx_flags}, 32'h1);
        chk("R13 vx_flags", {28'b0, vx_flags}, 32'h4);
    endtask

    task automatic t_sticky();
        repeat (5) step();
        chk("R7 sticky over idle", {25'b0, status}, 32'h14);
        @(negedge clk); mx_valid = 4'b0010; mx_undf = 4'b0010; step();
        chk("R7 accumulates", {25'b0, status}, 32'h54);
    endtask

    task automatic t_clear_race();
        @(negedge clk); clr = 1'b1; vx_valid = 4'b0100; vx_nan = 4'b0100; step();
        chk("R9 event wins over clear", {25'b0, status}, 32'h08);
        do_clear();
    endtask

    task automatic t_read();
        @(negedge clk); mx_valid = 4'b0001; mx_ovf = 4'b0001; step();
        @(negedge clk); rd_en = 1'b1; step();
        chk("R12 read data", rd_data, 32'h20);
        @(negedge clk); vx_valid = 4'b0001; vx_iovf = 4'b0001; step();
        chk("R12 held without rd_en", rd_data, 32'h20);
        @(negedge clk); rd_en = 1'b1; step();
        chk("R12 reread upper zero", rd_data, 32'h21);
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_bits();
        t_valid_mask();
        t_multi_lane();
        t_sticky();
        t_clear_race();
        t_read();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule